// File: doc/BRIEF.md
# Outgoing Store Drain Queue

This block sits between the processor's store path and the external system bus. It takes outgoing writes so that the processor can go on executing without owning the bus and without waiting for memory. Two kinds of fill are accepted. A single fill is one address/data doubleword pair from an uncached store. A line fill is a whole data-cache line from a writeback, handed over in one cycle. The queue then issues these writes to the bus in arrival order.

The bus side uses a valid/accept handshake. While entries are held, the valid signal stays high, so a bus that accepts every cycle gets one write per clock with no idle clocks between them. The processor uses an empty flag to wait until all earlier stores have left before it starts an operation that depends on their order.

Top module: `wbuf_top`

## Requirements
- R1: After reset `buf_empty` is 1, `bus_valid` is 0, and `in_ready` is 1 for a single fill (`in_is_line` = 0).
- R2: Single fills leave on the bus in the order they were accepted, each with its address and data unchanged.
- R3: While four entries are held, `in_ready` is 0 for a single fill, and a single fill offered then is not taken.
- R4: A line fill (`in_is_line` = 1) is accepted only when the queue is empty. While any entry is held, `in_ready` is 0 for a line fill.
- R5: An accepted line leaves as four consecutive beats. Beat i carries `in_line_data[64*i+63:64*i]` at address `in_addr + 8*i`.
- R6: While any beat of a line is still held, `in_ready` is 0 for both fill kinds.
- R7: While `bus_accept` is held high, `bus_valid` stays high in every cycle that entries remain, so writes follow back-to-back with no idle clock.
- R8: While `bus_valid` is 1 and `bus_accept` is 0, the offered write stays valid with `bus_addr` and `bus_data` unchanged.
- R9: `buf_empty` is 1 exactly when no entry is held, and `bus_valid` is 0 whenever `buf_empty` is 1.
- R10: A single fill and a bus accept in the same cycle both take effect: occupancy stays the same and order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Processor offers a fill |
| in_is_line | input | 1 | 1 = line fill, 0 = single fill |
| in_addr | input | ADDR_W | Store address, or line base address |
| in_data | input | DATA_W | Doubleword for a single fill |
| in_line_data | input | DEPTH*DATA_W | Whole line for a line fill, beat 0 in the low bits |
| in_ready | output | 1 | Fill of the offered kind can be taken this cycle |
| bus_valid | output | 1 | A write is offered on the bus |
| bus_addr | output | ADDR_W | Address of the offered write |
| bus_data | output | DATA_W | Data of the offered write |
| bus_accept | input | 1 | Bus takes the offered write this cycle |
| buf_empty | output | 1 | No write is held |

## Verification
The hardest case to reach from the ports is a line fill that lands while the write pointer is not at slot zero. In that case the beats wrap around the storage, and they must still leave in beat order. The stimulus table gets there by first passing an odd number of single fills through the queue, including one that is enqueued in the same cycle that another is drained. Only then does it offer a line. The table also holds a line request against a full queue, and it pauses the bus in the middle of the line, so that the refusal rule and the hold rule are both exercised together with the wrap.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
   // Kind of fill currently occupying the queue
   typedef enum logic [0:0] {
      FILL_SINGLE = 1'b0,
      FILL_LINE   = 1'b1
   } fill_kind_e;
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
   parameter int ADDR_W = 40,
   parameter int DATA_W = 64,
   parameter int DEPTH  = 4,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int OFF_W = $clog2(DATA_W / 8)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    single_we,
   input  logic                    line_we,
   input  logic [PTR_W-1:0]        wr_ptr,
   input  logic [PTR_W-1:0]        rd_ptr,
   input  logic [ADDR_W-1:0]       in_addr,
   input  logic [DATA_W-1:0]       in_data,
   input  logic [DEPTH*DATA_W-1:0] in_line_data,
   output logic [ADDR_W-1:0]       head_addr,
   output logic [DATA_W-1:0]       head_data
);
   logic [ADDR_W-1:0] slot_addr [DEPTH];
   logic [DATA_W-1:0] slot_data [DEPTH];

   for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      logic [PTR_W-1:0]  slot_id;
      logic [PTR_W-1:0]  beat;
      logic [ADDR_W-1:0] a_q;
      logic [DATA_W-1:0] d_q;

      assign slot_id = PTR_W'(k);
      // beat index of this slot relative to where the line starts
      assign beat    = slot_id - wr_ptr;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_q <= '0;
            d_q <= '0;
         end else if (line_we) begin
            a_q <= in_addr + (ADDR_W'(beat) << OFF_W);
            d_q <= in_line_data[int'(beat)*DATA_W +: DATA_W];
         end else if (single_we && (wr_ptr == slot_id)) begin
            a_q <= in_addr;
            d_q <= in_data;
         end
      end

      assign slot_addr[k] = a_q;
      assign slot_data[k] = d_q;
   end

   assign head_addr = slot_addr[rd_ptr];
   assign head_data = slot_data[rd_ptr];
endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
   import wbuf_pkg::*;
#(
   parameter int DEPTH  = 4,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_is_line,
   input  logic             bus_accept,
   output logic             in_ready,
   output logic             single_we,
   output logic             line_we,
   output logic             bus_valid,
   output logic             buf_empty,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr
);
   logic [CNT_W-1:0] count_q;
   fill_kind_e       kind_q;
   logic             deq;

   assign buf_empty = (count_q == '0);
   assign bus_valid = !buf_empty;
   assign in_ready  = (kind_q == FILL_SINGLE) &&
                      (in_is_line ? buf_empty : (count_q != CNT_W'(DEPTH)));
   assign single_we = in_valid && !in_is_line && in_ready;
   assign line_we   = in_valid &&  in_is_line && in_ready;
   assign deq       = bus_valid && bus_accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         kind_q  <= FILL_SINGLE;
      end else begin
         if (line_we) begin
            // queue is empty here, so no drain can coincide
            count_q <= CNT_W'(DEPTH);
            kind_q  <= FILL_LINE;
         end else begin
            count_q <= count_q + CNT_W'(single_we) - CNT_W'(deq);
            if (deq && (count_q == CNT_W'(1)))
               kind_q <= FILL_SINGLE;
         end
         if (single_we) wr_ptr <= wr_ptr + 1'b1;
         if (deq)       rd_ptr <= rd_ptr + 1'b1;
      end
   end
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top #(
   parameter int ADDR_W = 40,
   parameter int DATA_W = 64,
   parameter int DEPTH  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    in_is_line,
   input  logic [ADDR_W-1:0]       in_addr,
   input  logic [DATA_W-1:0]       in_data,
   input  logic [DEPTH*DATA_W-1:0] in_line_data,
   output logic                    in_ready,
   output logic                    bus_valid,
   output logic [ADDR_W-1:0]       bus_addr,
   output logic [DATA_W-1:0]       bus_data,
   input  logic                    bus_accept,
   output logic                    buf_empty
);
   localparam int PTR_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("wbuf_top: DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("wbuf_top: DATA_W must be a power of two number of bits, at least 8");
   end
   if (ADDR_W <= $clog2(DEPTH * DATA_W / 8)) begin : g_bad_addr
      $error("wbuf_top: ADDR_W too narrow for one line");
   end

   logic             single_we;
   logic             line_we;
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;

   wbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_is_line (in_is_line),
      .bus_accept (bus_accept),
      .in_ready   (in_ready),
      .single_we  (single_we),
      .line_we    (line_we),
      .bus_valid  (bus_valid),
      .buf_empty  (buf_empty),
      .wr_ptr     (wr_ptr),
      .rd_ptr     (rd_ptr)
   );

   wbuf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .single_we    (single_we),
      .line_we      (line_we),
      .wr_ptr       (wr_ptr),
      .rd_ptr       (rd_ptr),
      .in_addr      (in_addr),
      .in_data      (in_data),
      .in_line_data (in_line_data),
      .head_addr    (bus_addr),
      .head_data    (bus_data)
   );
endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
   parameter int ADDR_W = 40,
   parameter int DATA_W = 64,
   parameter int DEPTH  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_is_line,
   input logic              in_ready,
   input logic              bus_valid,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_data,
   input logic              bus_accept,
   input logic              buf_empty
);
   // occupancy seen from the ports alone
   int unsigned occ;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= 0;
      else occ <= occ
                  + ((in_valid && in_ready) ? (in_is_line ? DEPTH : 1) : 0)
                  - ((bus_valid && bus_accept) ? 1 : 0);
   end

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= DEPTH);

   a_r3_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == DEPTH && !in_is_line) |-> !in_ready);

   a_r4_line_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_is_line && in_ready) |-> (occ == 0));

   a_r7_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_accept && occ > 1) |=> bus_valid);

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_accept) |=>
         (bus_valid && $stable(bus_addr) && $stable(bus_data)));

   a_r9_empty_flag: assert property (@(posedge clk) disable iff (!rst_n)
      buf_empty == (occ == 0));

   a_r9_no_valid_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      buf_empty |-> !bus_valid);
endmodule

bind wbuf_top wbuf_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_is_line (in_is_line),
   .in_ready   (in_ready),
   .bus_valid  (bus_valid),
   .bus_addr   (bus_addr),
   .bus_data   (bus_data),
   .bus_accept (bus_accept),
   .buf_empty  (buf_empty)
);

// File: tb/sim_wbuf_top.sv
`timescale 1ns/1ps
module sim_wbuf_top;
   localparam int ADDR_W = 40;
   localparam int DATA_W = 64;
   localparam int DEPTH  = 4;
   localparam int NVEC   = 20;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    in_valid = 1'b0;
   logic                    in_is_line = 1'b0;
   logic [ADDR_W-1:0]       in_addr = '0;
   logic [DATA_W-1:0]       in_data = '0;
   logic [DEPTH*DATA_W-1:0] in_line_data = '0;
   logic                    in_ready;
   logic                    bus_valid;
   logic [ADDR_W-1:0]       bus_addr;
   logic [DATA_W-1:0]       bus_data;
   logic                    bus_accept = 1'b0;
   logic                    buf_empty;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   wbuf_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_line(in_is_line),
      .in_addr(in_addr), .in_data(in_data), .in_line_data(in_line_data),
      .in_ready(in_ready), .bus_valid(bus_valid), .bus_addr(bus_addr),
      .bus_data(bus_data), .bus_accept(bus_accept), .buf_empty(buf_empty)
   );

   // vector: {line, valid, accept, exp_ready, addr[15:0], seed[7:0]}
   typedef logic [27:0] vec_t;
   localparam vec_t VECS [NVEC] = '{
      {4'b0101, 16'h0100, 8'h11},   // single, ready
      {4'b0101, 16'h0108, 8'h12},
      {4'b0101, 16'h0110, 8'h13},
      {4'b0101, 16'h0118, 8'h14},   // now four held
      {4'b0100, 16'h0120, 8'h15},   // R3 refused when full
      {4'b1100, 16'h0200, 8'h20},   // R4 line refused, not empty
      {4'b0010, 16'h0000, 8'h00},   // drain, ready still low at full
      {4'b0111, 16'h0120, 8'h15},   // R10 fill and drain together
      {4'b0011, 16'h0000, 8'h00},
      {4'b0011, 16'h0000, 8'h00},
      {4'b0011, 16'h0000, 8'h00},   // last single leaves
      {4'b1101, 16'h0200, 8'h20},   // line at wrapped pointer
      {4'b0110, 16'h0300, 8'h30},   // R6 refused during line
      {4'b0110, 16'h0300, 8'h30},
      {4'b0000, 16'h0000, 8'h00},   // R8 bus stall mid-line
      {4'b0010, 16'h0000, 8'h00},
      {4'b0010, 16'h0000, 8'h00},   // last beat
      {4'b0111, 16'h0300, 8'h30},   // empty again: accepted
      {4'b0011, 16'h0000, 8'h00},
      {4'b0001, 16'h0000, 8'h00}
   };

   logic [ADDR_W-1:0] q_addr [$];
   logic [DATA_W-1:0] q_data [$];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Drive at negedge, sample before the next posedge, update model at the edge.
   task automatic step(input bit line, input bit valid, input bit acc,
                       input bit exp_rdy, input logic [15:0] a, input logic [7:0] s);
      @(negedge clk);
      in_is_line = line;
      in_valid   = valid;
      bus_accept = acc;
      in_addr    = ADDR_W'(a);
      in_data    = {8{s}};
      for (int i = 0; i < DEPTH; i++)
         in_line_data[i*DATA_W +: DATA_W] = {8{s + 8'(i)}};
      #2;
      check(in_ready == exp_rdy, line ? "R4/R6" : "R3/R6", "in_ready",
            64'(in_ready), 64'(exp_rdy));
      check(buf_empty == (q_addr.size() == 0), "R9", "buf_empty",
            64'(buf_empty), 64'(q_addr.size() == 0));
      check(bus_valid == (q_addr.size() != 0), "R7", "bus_valid",
            64'(bus_valid), 64'(q_addr.size() != 0));
      if (bus_valid && q_addr.size() != 0) begin
         check(bus_addr == q_addr[0], "R2/R5", "bus_addr",
               64'(bus_addr), 64'(q_addr[0]));
         check(bus_data == q_data[0], "R2/R5", "bus_data",
               64'(bus_data), 64'(q_data[0]));
      end
      @(posedge clk);
      if (bus_valid && acc && q_addr.size() != 0) begin
         void'(q_addr.pop_front());
         void'(q_data.pop_front());
      end
      if (valid && exp_rdy) begin
         if (line) begin
            for (int i = 0; i < DEPTH; i++) begin
               q_addr.push_back(ADDR_W'(a) + ADDR_W'(8 * i));
               q_data.push_back({8{s + 8'(i)}});
            end
         end else begin
            q_addr.push_back(ADDR_W'(a));
            q_data.push_back({8{s}});
         end
      end
   endtask

   initial begin
      #(8 * 5000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] hold_a;
      logic [63:0] hold_d;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check(buf_empty == 1'b1, "R1", "buf_empty", 64'(buf_empty), 64'd1);
      check(bus_valid == 1'b0, "R1", "bus_valid", 64'(bus_valid), 64'd0);
      check(in_ready  == 1'b1, "R1", "in_ready",  64'(in_ready),  64'd1);
      @(negedge clk);
      rst_n = 1'b1;

      for (int v = 0; v < NVEC; v++)
         step(VECS[v][27], VECS[v][26], VECS[v][25], VECS[v][24],
              VECS[v][23:8], VECS[v][7:0]);

      // R8 directed: stall with one entry, values must hold
      step(1'b0, 1'b1, 1'b0, 1'b1, 16'h0400, 8'h44);
      step(1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 8'h00);
      hold_a = 64'(bus_addr);
      hold_d = bus_data;
      step(1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 8'h00);
      check(64'(bus_addr) == hold_a && bus_valid, "R8", "held addr", 64'(bus_addr), hold_a);
      check(bus_data == hold_d, "R8", "held data", bus_data, hold_d);

      // R5 line whose beats carry into a higher address bit
      step(1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 8'h00);
      step(1'b1, 1'b1, 1'b0, 1'b1, 16'h0FF0, 8'h50);
      for (int i = 0; i < DEPTH; i++)
         step(1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 8'h00);
      step(1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 8'h00);

      // R1 reset with entries held
      step(1'b0, 1'b1, 1'b0, 1'b1, 16'h0500, 8'h55);
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      check(buf_empty == 1'b1 && !bus_valid, "R1", "empty after reset",
            64'(buf_empty), 64'd1);
      q_addr.delete();
      q_data.delete();
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 8'h00);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule